// File: doc/BRIEF.md
# Bidirectional Shift Register with Shared Parallel Port

This block is a clocked storage register of `WIDTH` bits that can hold its contents, shift toward its most significant bit, shift toward its least significant bit, or capture a parallel word. A two-bit mode select picks the action, which takes effect on each rising clock edge. An active-low clear, sampled at the same edge, zeroes the whole register and overrides every mode setting.

The parallel port serves as both input and output. It is presented as three vectors: `par_in` carries the levels seen on the pins, `par_out` always carries the register contents, and `par_oe` is the per-pin driver enable. The drivers are turned off while the mode is capture, so that external data can reach the pins, and also whenever either of two output-hide inputs is high. Hiding the port never affects clearing, shifting, holding or loading.

Two single-bit outputs, `low_end` and `high_end`, always show bit 0 and bit `WIDTH-1`. They are never disabled. This lets several registers be chained into a longer word, with one stage's end bit wired into the next stage's serial input.

The mode select is decoded into four named states: KEEP (`00`), UP (`01`), DOWN (`10`) and CAPTURE (`11`). Each edge moves the register along one of four transitions. KEEP leaves the word unchanged. UP moves every bit one place toward the top and feeds `fill_up` into bit 0. DOWN moves every bit one place toward the bottom and feeds `fill_down` into the top bit. CAPTURE takes the word from `par_in`. A low `clear_n` replaces whichever of these transitions is selected with a transition to all zeros.

Top module: `bidir_shift_reg`

## Requirements
- R1: `mode_sel` encodes the action taken at each rising edge as 00 KEEP, 01 UP, 10 DOWN, 11 CAPTURE, and the register changes only at rising edges.
- R2: When `clear_n` is 0 at a rising edge, the register becomes all zeros, whatever the values of `mode_sel`, the fill inputs and `par_in`.
- R3: In KEEP with `clear_n` high, the register keeps its value across the edge.
- R4: In UP, the new bit 0 is `fill_up` and the new bit i is the old bit i-1 for i from 1 to WIDTH-1.
- R5: In DOWN, the new bit WIDTH-1 is `fill_down` and the new bit i is the old bit i+1 for i from 0 to WIDTH-2.
- R6: In CAPTURE, the register takes the value of `par_in`, and every bit of `par_oe` is 0 whatever the hide inputs are.
- R7: When `hide_a` or `hide_b` is 1, every bit of `par_oe` is 0, and the register sequence is the same as it would be with both hide inputs low.
- R8: With both hide inputs low and a mode other than CAPTURE, every bit of `par_oe` is 1; `par_out` equals the register contents at all times.
- R9: `low_end` equals register bit 0 and `high_end` equals bit WIDTH-1 at all times, whatever the hide inputs and mode. Two registers chained through these outputs behave as one register of twice the width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, overrides the mode |
| mode_sel | input | 2 | Action select: 00 KEEP, 01 UP, 10 DOWN, 11 CAPTURE |
| hide_a | input | 1 | Output hide, active high |
| hide_b | input | 1 | Output hide, active high |
| fill_up | input | 1 | Serial bit entering bit 0 in UP |
| fill_down | input | 1 | Serial bit entering bit WIDTH-1 in DOWN |
| par_in | input | WIDTH | Levels on the shared port, captured in CAPTURE |
| par_out | output | WIDTH | Register contents offered to the port drivers |
| par_oe | output | WIDTH | Per-pin driver enable for the shared port |
| low_end | output | 1 | Always-driven copy of bit 0 |
| high_end | output | 1 | Always-driven copy of bit WIDTH-1 |

## Verification
The bench builds the register with `WIDTH` = 4. At that width it can sweep every starting word, every mode, every pair of fill bits, both clear levels and all four hide combinations, so every transition out of every state is compared with a shift-and-mask model. Two further 4-bit instances are chained through their end outputs and run UP and DOWN against an 8-bit model, which covers cascading across the stage boundary in both directions.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    // Register action selected for the next rising edge
    typedef enum logic [1:0] {
        MODE_KEEP    = 2'b00,
        MODE_UP      = 2'b01,
        MODE_DOWN    = 2'b10,
        MODE_CAPTURE = 2'b11
    } bsr_mode_e;

endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
    import bsr_pkg::*;
(
    input  logic [1:0] mode_sel,
    output bsr_mode_e  mode,
    output logic       capture
);

    always_comb begin
        mode    = bsr_mode_e'(mode_sel);
        capture = (mode == MODE_CAPTURE);
    end

endmodule

// File: rtl/bsr_store.sv
module bsr_store
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_n,
    input  bsr_mode_e        mode,
    input  logic             fill_up,
    input  logic             fill_down,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] word_q
);

    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] word_d;

    // Next-word selection; a low clear overrides every mode
    always_comb begin
        word_d = word_q;
        if (!clear_n) begin
            word_d = '0;
        end else begin
            unique case (mode)
                MODE_KEEP:    word_d = word_q;
                MODE_UP:      word_d = {word_q[TOP-1:0], fill_up};
                MODE_DOWN:    word_d = {fill_down, word_q[TOP:1]};
                MODE_CAPTURE: word_d = par_in;
                default:      word_d = word_q;
            endcase
        end
    end

    // Register with no reset: the synchronous clear gives the known state
    always_ff @(posedge clk) begin
        word_q <= word_d;
    end

endmodule

// File: rtl/bsr_port_gate.sv
module bsr_port_gate #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] word_q,
    input  logic             capture,
    input  logic             hide_a,
    input  logic             hide_b,
    output logic [WIDTH-1:0] par_out,
    output logic [WIDTH-1:0] par_oe,
    output logic             low_end,
    output logic             high_end
);

    logic drive_en;

    always_comb begin
        drive_en = ~hide_a & ~hide_b & ~capture;
        par_out  = word_q;
        low_end  = word_q[0];
        high_end = word_q[WIDTH-1];
    end

    // One driver enable per pin of the shared port
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign par_oe[i] = drive_en;
    end

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
    import bsr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             clear_n,
    input  logic [1:0]       mode_sel,
    input  logic             hide_a,
    input  logic             hide_b,
    input  logic             fill_up,
    input  logic             fill_down,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] par_out,
    output logic [WIDTH-1:0] par_oe,
    output logic             low_end,
    output logic             high_end
);

    bsr_mode_e        mode;
    logic             capture;
    logic [WIDTH-1:0] word_q;

    bsr_mode_decode u_decode (
        .mode_sel (mode_sel),
        .mode     (mode),
        .capture  (capture)
    );

    bsr_store #(.WIDTH(WIDTH)) u_store (
        .clk       (clk),
        .clear_n   (clear_n),
        .mode      (mode),
        .fill_up   (fill_up),
        .fill_down (fill_down),
        .par_in    (par_in),
        .word_q    (word_q)
    );

    bsr_port_gate #(.WIDTH(WIDTH)) u_gate (
        .word_q   (word_q),
        .capture  (capture),
        .hide_a   (hide_a),
        .hide_b   (hide_b),
        .par_out  (par_out),
        .par_oe   (par_oe),
        .low_end  (low_end),
        .high_end (high_end)
    );

endmodule

// File: rtl/bidir_shift_reg_chk.sv
module bidir_shift_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             clear_n,
    input logic [1:0]       mode_sel,
    input logic             hide_a,
    input logic             hide_b,
    input logic             fill_up,
    input logic             fill_down,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] par_out,
    input logic [WIDTH-1:0] par_oe,
    input logic             low_end,
    input logic             high_end
);

    // Becomes 1 after the first clear edge; before that the register is unknown
    logic primed = 1'b0;
    always_ff @(posedge clk) begin
        if (!clear_n) primed <= 1'b1;
    end

    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!primed)
        !clear_n |=> (par_out == '0));

    p_keep_stable_r3: assert property (@(posedge clk) disable iff (!primed)
        (clear_n && mode_sel == 2'b00) |=> $stable(par_out));

    p_shift_up_r4: assert property (@(posedge clk) disable iff (!primed)
        (clear_n && mode_sel == 2'b01) |=>
            (par_out == {$past(par_out[WIDTH-2:0]), $past(fill_up)}));

    p_shift_down_r5: assert property (@(posedge clk) disable iff (!primed)
        (clear_n && mode_sel == 2'b10) |=>
            (par_out == {$past(fill_down), $past(par_out[WIDTH-1:1])}));

    p_capture_load_r6: assert property (@(posedge clk) disable iff (!primed)
        (clear_n && mode_sel == 2'b11) |=> (par_out == $past(par_in)));

    p_capture_float_r6: assert property (@(posedge clk) disable iff (!primed)
        (mode_sel == 2'b11) |-> (par_oe == '0));

    p_hide_float_r7: assert property (@(posedge clk) disable iff (!primed)
        (hide_a || hide_b) |-> (par_oe == '0));

    p_drive_on_r8: assert property (@(posedge clk) disable iff (!primed)
        (!hide_a && !hide_b && mode_sel != 2'b11) |-> (par_oe == '1));

    p_end_bits_r9: assert property (@(posedge clk) disable iff (!primed)
        (low_end == par_out[0]) && (high_end == par_out[WIDTH-1]));

endmodule

bind bidir_shift_reg bidir_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .clear_n   (clear_n),
    .mode_sel  (mode_sel),
    .hide_a    (hide_a),
    .hide_b    (hide_b),
    .fill_up   (fill_up),
    .fill_down (fill_down),
    .par_in    (par_in),
    .par_out   (par_out),
    .par_oe    (par_oe),
    .low_end   (low_end),
    .high_end  (high_end)
);

// File: tb/test_bidir_shift_reg.sv
module test_bidir_shift_reg;

    localparam int W    = 4;
    localparam int MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         clear_n = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic         hide_a = 1'b0;
    logic         hide_b = 1'b0;
    logic         fill_up = 1'b0;
    logic         fill_down = 1'b0;
    logic [W-1:0] par_in = '0;
    logic [W-1:0] par_out;
    logic [W-1:0] par_oe;
    logic         low_end;
    logic         high_end;

    // Cascade pair: lo holds bits 0..W-1, hi holds bits W..2W-1
    logic         c_clear_n = 1'b0;
    logic [1:0]   c_mode = 2'b00;
    logic         c_fill_up = 1'b0;
    logic         c_fill_down = 1'b0;
    logic [W-1:0] c_in_lo = '0;
    logic [W-1:0] c_in_hi = '0;
    logic [W-1:0] c_out_lo, c_out_hi, c_oe_lo, c_oe_hi;
    logic         lo_low, lo_high, hi_low, hi_high;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bidir_shift_reg #(.WIDTH(W)) i_bidir_shift_reg (
        .clk(clk), .clear_n(clear_n), .mode_sel(mode_sel),
        .hide_a(hide_a), .hide_b(hide_b),
        .fill_up(fill_up), .fill_down(fill_down), .par_in(par_in),
        .par_out(par_out), .par_oe(par_oe),
        .low_end(low_end), .high_end(high_end)
    );

    bidir_shift_reg #(.WIDTH(W)) i_casc_lo (
        .clk(clk), .clear_n(c_clear_n), .mode_sel(c_mode),
        .hide_a(1'b1), .hide_b(1'b0),
        .fill_up(c_fill_up), .fill_down(hi_low), .par_in(c_in_lo),
        .par_out(c_out_lo), .par_oe(c_oe_lo),
        .low_end(lo_low), .high_end(lo_high)
    );

    bidir_shift_reg #(.WIDTH(W)) i_casc_hi (
        .clk(clk), .clear_n(c_clear_n), .mode_sel(c_mode),
        .hide_a(1'b0), .hide_b(1'b1),
        .fill_up(lo_high), .fill_down(c_fill_down), .par_in(c_in_hi),
        .par_out(c_out_hi), .par_oe(c_oe_hi),
        .low_end(hi_low), .high_end(hi_high)
    );

    task automatic check(input string req, input int actual, input int expected, input string what);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, actual, expected);
        end
    endtask

    // Inputs change 1 ns after a rising edge; results are read there too
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int model_next(int s, int m, int clr, int fu, int fd, int din);
        if (clr == 0) return 0;
        case (m)
            0: return s;
            1: return ((s << 1) | fu) & MASK;
            2: return (s >> 1) | (fd << (W - 1));
            default: return din & MASK;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog run did not finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #1;
        clear_n = 1'b0; mode_sel = 2'b11; par_in = 4'hF;
        c_clear_n = 1'b0;
        tick();
        tick();
        // R2: clear wins even while CAPTURE is selected with all-ones data
        check("R2", int'(par_out), 0, "reset state");
        check("R9", int'({high_end, low_end}), 0, "reset end bits");
        check("R6", int'(par_oe), 0, "oe off in capture during clear");

        for (int s = 0; s < 16; s++) begin
            for (int m = 0; m < 4; m++) begin
                for (int f = 0; f < 4; f++) begin
                    for (int clr = 0; clr < 2; clr++) begin
                        for (int h = 0; h < 4; h++) begin
                            int exp_v;
                            int din;
                            // preload s through CAPTURE
                            clear_n = 1'b1; mode_sel = 2'b11;
                            hide_a = 1'b0; hide_b = 1'b0;
                            par_in = W'(s);
                            tick();
                            check("R6", int'(par_out), s, "capture preload");
                            // apply the swept action
                            din = (s * 5 + 3) & MASK;
                            clear_n = clr[0]; mode_sel = m[1:0];
                            fill_up = f[0]; fill_down = f[1];
                            hide_a = h[0]; hide_b = h[1];
                            par_in = W'(din);
                            #1;
                            if (h != 0)
                                check("R7", int'(par_oe), 0, "hidden port oe");
                            else if (m == 3)
                                check("R6", int'(par_oe), 0, "capture port oe");
                            else
                                check("R8", int'(par_oe), MASK, "driven port oe");
                            tick();
                            exp_v = model_next(s, m, clr, f & 1, f >> 1, din);
                            if (clr == 0)       check("R2", int'(par_out), exp_v, "clear over mode");
                            else if (m == 0)    check("R3", int'(par_out), exp_v, "keep");
                            else if (m == 1)    check("R4", int'(par_out), exp_v, "shift up");
                            else if (m == 2)    check("R5", int'(par_out), exp_v, "shift down");
                            else                check("R1", int'(par_out), exp_v, "capture edge");
                            if (h != 0)
                                check("R7", int'(par_out), exp_v, "sequence under hide");
                            check("R9", int'(low_end), exp_v & 1, "low end bit");
                            check("R9", int'(high_end), (exp_v >> (W - 1)) & 1, "high end bit");
                            // R1: between edges nothing moves
                            #1;
                            check("R1", int'(par_out), exp_v, "stable between edges");
                        end
                    end
                end
            end
        end

        // Cascade: clear, load 8-bit word, then shift up and down
        begin
            int word8;
            c_clear_n = 1'b0; c_mode = 2'b00;
            tick();
            check("R9", int'({c_out_hi, c_out_lo}), 0, "cascade clear");
            c_clear_n = 1'b1; c_mode = 2'b11;
            c_in_lo = 4'h6; c_in_hi = 4'hB;
            word8 = 8'hB6;
            tick();
            check("R9", int'({c_out_hi, c_out_lo}), word8, "cascade load");
            for (int k = 0; k < 12; k++) begin
                int fu;
                fu = (k * 3 + 1) % 2;
                c_mode = 2'b01; c_fill_up = fu[0];
                tick();
                word8 = ((word8 << 1) | fu) & 8'hFF;
                check("R9", int'({c_out_hi, c_out_lo}), word8, "cascade up");
            end
            for (int k = 0; k < 12; k++) begin
                int fd;
                fd = (k / 2) % 2;
                c_mode = 2'b10; c_fill_down = fd[0];
                tick();
                word8 = (word8 >> 1) | (fd << 7);
                check("R9", int'({c_out_hi, c_out_lo}), word8, "cascade down");
            end
            check("R7", int'({c_oe_hi, c_oe_lo}), 0, "cascade ports hidden");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule